// File: doc/BRIEF.md
# Bus Arbiter Error and Control Register Slice

This block is the software-visible register set that sits beside a local bus arbiter on a device control register bus. It holds a control word for the arbiter, a bus error address register and a bus error status register. Software reaches them through a simple strobe interface: one access per cycle, a write flag, a 10-bit register number and 32-bit data. Read data is combinational and valid in the cycle of the read strobe.

The arbiter's control register answers at one primary number and at three alias numbers. Only the primary number returns its contents. The aliases accept an access, return zero and drop writes. On the hardware side, the arbitration logic reports a bus error with a one-cycle pulse that carries the faulting address and a status vector. The status vector accumulates into the status register, and software clears it by writing ones. The address register is read-only to software. It keeps the address of the first error that occurs while the status register is clear.

Top module: `arbctl_regs`

## Requirements
- R1: After reset the control, error address and error status registers all read zero, and `arb_ctrl` is zero.
- R2: A write to register 0x087 stores only bits 31:27 of the write data and clears every other bit. A read of 0x087 returns the stored value.
- R3: Registers 0x077, 0x081 and 0x089 are control aliases. A read of any of them returns zero, and a write to any of them leaves the control register unchanged.
- R4: A software write to register 0x086, the error address register, has no effect on its contents.
- R5: A write to register 0x084, the error status register, clears each status bit whose write data bit is 1 and leaves the other bits unchanged.
- R6: A cycle with `err_pulse` high ORs `err_status` into the error status register.
- R7: When an error pulse and a software clear of 0x084 occur in the same cycle, every bit set by the pulse is 1 afterwards.
- R8: An error pulse loads `err_addr` into register 0x086 only if the status register was all zero before that cycle. Otherwise the stored address is kept.
- R9: A read of any register number other than 0x077, 0x081, 0x084, 0x086, 0x087 and 0x089 returns zero. A write to such a number changes none of the registers.
- R10: `reg_rdata` is zero in every cycle without a read, that is, unless `reg_en` is high and `reg_wr` is low.
- R11: `arb_ctrl` always equals the contents of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Register number |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read |
| err_pulse | input | 1 | One-cycle bus error report |
| err_addr | input | 32 | Faulting bus address |
| err_status | input | 32 | Error status bits to accumulate |
| arb_ctrl | output | 32 | Current control word for the arbitration logic |

## Verification
The assertions check several rules on every cycle. Idle read data stays zero. The control word has no bits outside 31:27 and changes only after a write to the primary number. Pulsed status bits are present in the next cycle, whatever software wrote. Status bits written as one are gone unless they were re-set. The error address holds while status is nonzero and loads when status was clear. The bench scenarios cover the rest. These are alias reads returning zero while the register holds data, write-ignore at 0x086 and at unmapped numbers, and address capture across a clear-then-error sequence. Each of these is seen only by comparing a read value against a reference model.

// File: rtl/arbctl_pkg.sv
package arbctl_pkg;
    localparam int REG_NUM_W = 10;

    // register numbers; the primary control number is the only readable one
    localparam logic [REG_NUM_W-1:0] NUM_STAT  = 10'h084;
    localparam logic [REG_NUM_W-1:0] NUM_EADDR = 10'h086;
    localparam logic [REG_NUM_W-1:0] NUM_CTRL  = 10'h087;

    localparam int N_ALIAS = 3;
    localparam logic [N_ALIAS*REG_NUM_W-1:0] ALIAS_NUMS = {10'h089, 10'h081, 10'h077};

    typedef struct packed {
        logic rd;        // read strobe
        logic ctrl_hit;  // primary control number
        logic alias_hit; // any alias number
        logic eaddr_hit;
        logic stat_hit;
    } dec_t;
endpackage

// File: rtl/arbctl_decode.sv
module arbctl_decode
    import arbctl_pkg::*;
#(
    parameter int ADDR_W = REG_NUM_W
) (
    input  logic              en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] num,
    output dec_t              dec
);
    localparam int CMP_W = (ADDR_W > REG_NUM_W) ? ADDR_W : REG_NUM_W;

    logic [CMP_W-1:0]   num_x;
    logic [N_ALIAS-1:0] alias_vec;

    assign num_x = CMP_W'(num);

    for (genvar i = 0; i < N_ALIAS; i++) begin : g_alias
        assign alias_vec[i] = en && (num_x == CMP_W'(ALIAS_NUMS[i*REG_NUM_W +: REG_NUM_W]));
    end

    always_comb begin
        dec           = '0;
        dec.rd        = en && !wr;
        dec.ctrl_hit  = en && (num_x == CMP_W'(NUM_CTRL));
        dec.eaddr_hit = en && (num_x == CMP_W'(NUM_EADDR));
        dec.stat_hit  = en && (num_x == CMP_W'(NUM_STAT));
        dec.alias_hit = |alias_vec;
    end
endmodule

// File: rtl/arbctl_ctrl_reg.sv
module arbctl_ctrl_reg #(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] KEEP_MASK = 32'hF800_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl = wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.ctrl;
endmodule

// File: rtl/arbctl_err_capture.sv
module arbctl_err_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_bits,
    input  logic              err_pulse,
    input  logic [DATA_W-1:0] err_addr,
    input  logic [DATA_W-1:0] err_status,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] eaddr_q
);
    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] eaddr;
    } err_state_t;

    err_state_t        st_d, st_q;
    logic [DATA_W-1:0] clr_v;
    logic [DATA_W-1:0] set_v;

    always_comb begin
        st_d  = st_q;
        clr_v = clr_en ? clr_bits : '0;
        set_v = err_pulse ? err_status : '0;
        // set applied after clear so hardware wins
        st_d.stat = (st_q.stat & ~clr_v) | set_v;
        if (err_pulse && (st_q.stat == '0)) begin
            st_d.eaddr = err_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q  = st_q.stat;
    assign eaddr_q = st_q.eaddr;
endmodule

// File: rtl/arbctl_regs.sv
module arbctl_regs
    import arbctl_pkg::*;
#(
    parameter int                ADDR_W    = REG_NUM_W,
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] CTRL_KEEP = 32'hF800_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              err_pulse,
    input  logic [DATA_W-1:0] err_addr,
    input  logic [DATA_W-1:0] err_status,
    output logic [DATA_W-1:0] arb_ctrl
);
    dec_t              dec;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] eaddr_q;

    arbctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .en  (reg_en),
        .wr  (reg_wr),
        .num (reg_addr),
        .dec (dec)
    );

    arbctl_ctrl_reg #(.DATA_W(DATA_W), .KEEP_MASK(CTRL_KEEP)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (dec.ctrl_hit && reg_wr),
        .wdata  (reg_wdata),
        .ctrl_q (ctrl_q)
    );

    arbctl_err_capture #(.DATA_W(DATA_W)) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_en     (dec.stat_hit && reg_wr),
        .clr_bits   (reg_wdata),
        .err_pulse  (err_pulse),
        .err_addr   (err_addr),
        .err_status (err_status),
        .stat_q     (stat_q),
        .eaddr_q    (eaddr_q)
    );

    always_comb begin
        reg_rdata = '0;
        if (dec.rd) begin
            if (dec.ctrl_hit) begin
                reg_rdata = ctrl_q;
            end else if (dec.eaddr_hit) begin
                reg_rdata = eaddr_q;
            end else if (dec.stat_hit) begin
                reg_rdata = stat_q;
            end else if (dec.alias_hit) begin
                reg_rdata = '0;
            end
        end
    end

    assign arb_ctrl = ctrl_q;
endmodule

// File: rtl/arbctl_regs_chk.sv
module arbctl_regs_chk
    import arbctl_pkg::*;
#(
    parameter int                ADDR_W    = REG_NUM_W,
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] CTRL_KEEP = 32'hF800_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              err_pulse,
    input logic [DATA_W-1:0] err_addr,
    input logic [DATA_W-1:0] err_status,
    input logic [DATA_W-1:0] arb_ctrl,
    input logic [DATA_W-1:0] stat_q,
    input logic [DATA_W-1:0] eaddr_q
);
    logic ctrl_write;
    logic stat_write;
    assign ctrl_write = reg_en && reg_wr && (32'(reg_addr) == 32'(NUM_CTRL));
    assign stat_write = reg_en && reg_wr && (32'(reg_addr) == 32'(NUM_STAT));

    // R10
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_wr) |-> (reg_rdata == '0));

    // R2
    ctrl_kept_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_ctrl & ~CTRL_KEEP) == '0);

    // R3
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_write |=> $stable(arb_ctrl));

    // R7
    err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> ((stat_q & $past(err_status)) == $past(err_status)));

    // R5
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_write && !err_pulse) |=> ((stat_q & $past(reg_wdata)) == '0));

    // R8
    eaddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q != '0) |=> $stable(eaddr_q));

    // R8
    eaddr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && (stat_q == '0)) |=> (eaddr_q == $past(err_addr)));
endmodule

bind arbctl_regs arbctl_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_KEEP(CTRL_KEEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en     (reg_en),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .err_pulse  (err_pulse),
    .err_addr   (err_addr),
    .err_status (err_status),
    .arb_ctrl   (arb_ctrl),
    .stat_q     (stat_q),
    .eaddr_q    (eaddr_q)
);

// File: tb/sim_arbctl_regs.sv
module sim_arbctl_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_pulse = 1'b0;
    logic [31:0] err_addr = '0;
    logic [31:0] err_status = '0;
    logic [31:0] arb_ctrl;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_ctrl, m_stat, m_eaddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    arbctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_pulse(err_pulse), .err_addr(err_addr), .err_status(err_status),
        .arb_ctrl(arb_ctrl)
    );

    function automatic logic [31:0] model_read(logic [9:0] a);
        case (a)
            10'h087: return m_ctrl;
            10'h086: return m_eaddr;
            10'h084: return m_stat;
            default: return 32'h0;   // aliases and unmapped
        endcase
    endfunction

    function automatic string tag_of(logic [9:0] a);
        case (a)
            10'h087: return "R2";
            10'h077, 10'h081, 10'h089: return "R3";
            10'h086: return "R8";
            10'h084: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle; checks read data and control output before the edge
    task automatic cyc(bit en, bit wr, logic [9:0] a, logic [31:0] wd,
                       bit ep, logic [31:0] ea, logic [31:0] es, string tag);
        logic [31:0] clr;
        @(negedge clk);
        reg_en = en; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        err_pulse = ep; err_addr = ea; err_status = es;
        #1;
        if (en && !wr)
            check((tag == "") ? tag_of(a) : tag, reg_rdata, model_read(a));
        else
            check("R10", reg_rdata, 32'h0);
        check("R11", arb_ctrl, m_ctrl);
        @(posedge clk);
        clr = (en && wr && a == 10'h084) ? wd : 32'h0;
        if (ep && m_stat == 32'h0) m_eaddr = ea;
        m_stat = (m_stat & ~clr) | (ep ? es : 32'h0);
        if (en && wr && a == 10'h087) m_ctrl = wd & 32'hF800_0000;
    endtask

    task automatic rd(logic [9:0] a, string tag);
        cyc(1, 0, a, 32'h0, 0, 32'h0, 32'h0, tag);
    endtask

    task automatic wrr(logic [9:0] a, logic [31:0] d);
        cyc(1, 1, a, d, 0, 32'h0, 32'h0, "");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_ctrl = '0; m_stat = '0; m_eaddr = '0;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        rd(10'h087, "R1"); rd(10'h086, "R1"); rd(10'h084, "R1");
        check("R1", arb_ctrl, 32'h0);

        // R2 masking
        wrr(10'h087, 32'hFFFF_FFFF);
        rd(10'h087, "R2");
        check("R2", model_read(10'h087), 32'hF800_0000);

        // R3 aliases read zero, writes ignored
        wrr(10'h077, 32'h0800_0000);
        wrr(10'h081, 32'h1000_0000);
        wrr(10'h089, 32'h0000_0000);
        rd(10'h077, "R3"); rd(10'h081, "R3"); rd(10'h089, "R3");
        rd(10'h087, "R3");

        // R9 unmapped
        wrr(10'h085, 32'hFFFF_FFFF);
        rd(10'h085, "R9"); rd(10'h3FF, "R9"); rd(10'h087, "R9");

        // R10 idle cycle
        cyc(0, 0, 10'h087, 32'h0, 0, 32'h0, 32'h0, "R10");

        // R6 / R8 first error captured
        cyc(0, 0, 10'h0, 32'h0, 1, 32'hAAAA_0000, 32'h0000_0005, "");
        rd(10'h084, "R6"); rd(10'h086, "R8");
        // R8 later error does not overwrite
        cyc(0, 0, 10'h0, 32'h0, 1, 32'hBBBB_0000, 32'h0000_0010, "");
        rd(10'h086, "R8"); rd(10'h084, "R6");

        // R4 write to address register ignored
        wrr(10'h086, 32'h1234_5678);
        rd(10'h086, "R4");

        // R5 partial clear
        wrr(10'h084, 32'h0000_0004);
        rd(10'h084, "R5");

        // R7 set wins over same-cycle clear
        cyc(1, 1, 10'h084, 32'hFFFF_FFFF, 1, 32'hCCCC_0000, 32'h0000_0003, "");
        rd(10'h084, "R7");
        check("R7", model_read(10'h084), 32'h0000_0003);

        // R8 capture again once status cleared
        wrr(10'h084, 32'hFFFF_FFFF);
        cyc(0, 0, 10'h0, 32'h0, 1, 32'hDDDD_0000, 32'h0000_0100, "");
        rd(10'h086, "R8");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [9:0] a;
            case ($urandom % 8)
                0: a = 10'h077;
                1: a = 10'h081;
                2: a = 10'h084;
                3: a = 10'h086;
                4: a = 10'h087;
                5: a = 10'h089;
                default: a = 10'($urandom);
            endcase
            cyc(($urandom % 4) != 0, ($urandom % 2) == 1, a, $urandom,
                ($urandom % 6) == 0, $urandom,
                (($urandom % 3) == 0) ? 32'h0 : ($urandom & 32'h0000_00FF), "");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule